// File: doc/BRIEF.md
# Power Switch Ramp Sequencer

This block sets the 8-bit control word of the power clamp for one processor core. An open request moves the clamp from fully closed to fully open through a fixed series of intermediate words. Each word is held for a timed interval so that the supply current rises in stages rather than all at once. A close request returns the clamp to the fully closed word in a single step, which is then held for one interval. The control word uses 0xFF for fully closed and 0x00 for fully open.

The caller raises a one-cycle request and waits for the done pulse. Before it starts an open, the block reads the present switch word. If the clamp is already open, no step is issued and completion is reported at once. The interval length in cycles is `CYC_PER_US * HOLD_US`. With the default 125 MHz clock this is 10 microseconds. While a sequence runs, further requests are dropped. They are not queued.

Top module: `pwr_ramp_seq`

## Requirements
- R1: During and after reset, sw_ctrl_o is 0xFF, busy_o is 0 and done_o is 0.
- R2: An accepted open request drives sw_ctrl_o through 0xFF, 0xFE, 0xF8, 0xF0, 0x00, in that order. The first word appears in the cycle after acceptance.
- R3: Each word of a sequence is held for exactly HOLD = CYC_PER_US*HOLD_US cycles. An open request takes 5*HOLD cycles from the first word to the end of the last hold. A close request takes HOLD cycles.
- R4: An open request seen while sw_state_i is 0x00 issues no step and leaves sw_ctrl_o unchanged. busy_o stays 0, and done_o rises in the next cycle. The decision follows sw_state_i, not the block's own output word.
- R5: An accepted close request drives sw_ctrl_o to 0xFF in the next cycle and holds it for one interval. done_o then pulses.
- R6: busy_o is 1 from the cycle after acceptance until the final hold expires. Requests seen while busy_o is 1 have no effect on sw_ctrl_o or on the timing of done_o. This includes a request in the last busy cycle.
- R7: done_o is a one-cycle pulse in the cycle after the final hold expires, and busy_o is 0 in that cycle. A request presented in that cycle is accepted.
- R8: If open and close are requested in the same idle cycle, the close is taken.
- R9: A close request is executed, with its full hold, even when sw_ctrl_o is already 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_req_i | input | 1 | Request to open the clamp (ramp to 0x00) |
| close_req_i | input | 1 | Request to close the clamp (0xFF) |
| sw_state_i | input | 8 | Present switch word read back from the clamp |
| sw_ctrl_o | output | 8 | Clamp control word |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The done pulse of one sequence and the acceptance of the next request can fall in the same cycle. To provoke this, the bench ends a close and presents an open request in exactly the cycle where done_o is high. It then expects the full open ramp to start in the following cycle. The converse edge is also driven: a request placed in the last busy cycle, one cycle earlier, must leave no trace. A scoreboard checks the value and the cycle of every word change and every done pulse against times computed from HOLD.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;

  localparam int WORD_W     = 8;
  localparam int OPEN_STEPS = 5;
  localparam int IDX_W      = 3;

  localparam logic [WORD_W-1:0] WORD_CLOSED = 8'hFF;
  localparam logic [WORD_W-1:0] WORD_OPEN   = 8'h00;

  typedef enum logic {
    MODE_OPEN  = 1'b0,
    MODE_CLOSE = 1'b1
  } mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } state_e;

  // Clamp word applied at each position of the opening ramp.
  function automatic logic [WORD_W-1:0] open_word(input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    case (idx)
      3'd0:    w = 8'hFF;
      3'd1:    w = 8'hFE;
      3'd2:    w = 8'hF8;
      3'd3:    w = 8'hF0;
      default: w = 8'h00;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pwr_ramp_timer.sv
module pwr_ramp_timer #(
  parameter int HOLD_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R3: the counter never runs above one interval
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

  // R3: a fresh load is followed by a running (non-expired) interval when HOLD exceeds one
  a_r3_load_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && HOLD_CYC > 1) |=> !expired_o);

endmodule

// File: rtl/pwr_ramp_steps.sv
module pwr_ramp_steps
  import pwr_ramp_pkg::*;
(
  input  mode_e              mode_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [WORD_W-1:0]  word_o
);

  always_comb begin
    if (mode_i == MODE_CLOSE) begin
      word_o = WORD_CLOSED;
    end else begin
      word_o = open_word(idx_i);
    end
  end

endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
  import pwr_ramp_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int HOLD_US    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open_req_i,
  input  logic       close_req_i,
  input  logic [7:0] sw_state_i,
  output logic [7:0] sw_ctrl_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int HOLD_CYC = CYC_PER_US * HOLD_US;
  localparam logic [IDX_W-1:0] LAST_OPEN_IDX = IDX_W'(OPEN_STEPS - 1);

  state_e              state_q, state_d;
  mode_e               mode_q, mode_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [WORD_W-1:0]   ctrl_q, nxt_word;
  logic                done_q, done_d;
  logic                word_upd;
  logic                tmr_load;
  logic                tmr_expired;
  logic                cur_last;

  pwr_ramp_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .expired_o (tmr_expired)
  );

  pwr_ramp_steps u_steps (
    .mode_i (mode_d),
    .idx_i  (idx_d),
    .word_o (nxt_word)
  );

  assign cur_last = (mode_q == MODE_CLOSE) ? (idx_q == '0) : (idx_q == LAST_OPEN_IDX);

  // Next-state process
  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    word_upd = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (close_req_i) begin
          mode_d   = MODE_CLOSE;
          idx_d    = '0;
          state_d  = ST_RAMP;
          tmr_load = 1'b1;
          word_upd = 1'b1;
        end else if (open_req_i) begin
          if (sw_state_i == WORD_OPEN) begin
            done_d = 1'b1;
          end else begin
            mode_d   = MODE_OPEN;
            idx_d    = '0;
            state_d  = ST_RAMP;
            tmr_load = 1'b1;
            word_upd = 1'b1;
          end
        end
      end
      ST_RAMP: begin
        if (tmr_expired) begin
          if (cur_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d    = idx_q + 1'b1;
            tmr_load = 1'b1;
            word_upd = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_CLOSE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= WORD_CLOSED;
    end else if (word_upd) begin
      ctrl_q <= nxt_word;
    end
  end

  assign sw_ctrl_o = ctrl_q;
  assign busy_o    = (state_q == ST_RAMP);
  assign done_o    = done_q;

  // R2: while opening, every change of the word moves one position along the ramp
  a_r2_ramp_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o && mode_q == MODE_OPEN && !$stable(sw_ctrl_o)) |->
      (($past(sw_ctrl_o) == 8'hFF && sw_ctrl_o == 8'hFE) ||
       ($past(sw_ctrl_o) == 8'hFE && sw_ctrl_o == 8'hF8) ||
       ($past(sw_ctrl_o) == 8'hF8 && sw_ctrl_o == 8'hF0) ||
       ($past(sw_ctrl_o) == 8'hF0 && sw_ctrl_o == 8'h00)));

  // R3: the word only moves on within a sequence after the interval has run out
  a_r3_step_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o && !$stable(sw_ctrl_o)) |-> $past(tmr_expired));

  // R4: an open on an already open clamp completes at once without a step
  a_r4_skip_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && open_req_i && !close_req_i && sw_state_i == WORD_OPEN) |=>
      (done_o && !busy_o && $stable(sw_ctrl_o)));

  // R5 / R8: an idle close request wins and closes the clamp next cycle
  a_r5_close_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && close_req_i) |=> (busy_o && sw_ctrl_o == WORD_CLOSED && mode_q == MODE_CLOSE));

  // R6: a running sequence keeps its mode whatever requests arrive
  a_r6_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> $stable(mode_q));

  // R7: completion is reported only outside a sequence
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7: a sequence ends with a done pulse
  a_r7_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

endmodule

// File: tb/test_pwr_ramp_seq.sv
module test_pwr_ramp_seq;

  localparam int CPU  = 4;
  localparam int HUS  = 10;
  localparam int H    = CPU * HUS;

  typedef struct {
    logic       is_done;
    logic [7:0] word;
    int         t;
    string      req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       open_req;
  logic       close_req;
  logic       force_open;
  logic [7:0] sw_state;
  logic [7:0] sw_ctrl;
  logic       busy;
  logic       done;

  int   compared;
  int   mismatched;
  int   cyc;
  logic [7:0] prev_word;
  logic mon_en;
  exp_t q[$];

  assign sw_state = force_open ? 8'h00 : sw_ctrl;

  pwr_ramp_seq #(
    .CYC_PER_US (CPU),
    .HOLD_US    (HUS)
  ) i_pwr_ramp_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_req_i  (open_req),
    .close_req_i (close_req),
    .sw_state_i  (sw_state),
    .sw_ctrl_o   (sw_ctrl),
    .busy_o      (busy),
    .done_o      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every word change and every done pulse is popped and compared
  always @(negedge clk) begin
    if (mon_en) begin
      if (sw_ctrl !== prev_word) begin
        compared++;
        if (q.size() == 0) begin
          mismatched++;
          $display("FAIL unexpected word change: actual %h at %0d, expected none", sw_ctrl, cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_done || e.word !== sw_ctrl || e.t != cyc) begin
            mismatched++;
            $display("FAIL %s: actual word %h at %0d, expected %s %h at %0d",
                     e.req, sw_ctrl, cyc, e.is_done ? "done" : "word", e.word, e.t);
          end
        end
      end
      if (done === 1'b1) begin
        compared++;
        if (q.size() == 0) begin
          mismatched++;
          $display("FAIL unexpected done pulse at %0d, expected none", cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (!e.is_done || e.t != cyc) begin
            mismatched++;
            $display("FAIL %s: actual done at %0d, expected %s %h at %0d",
                     e.req, cyc, e.is_done ? "done" : "word", e.word, e.t);
          end
        end
      end
      prev_word = sw_ctrl;
    end
  end

  task automatic push(input logic d, input logic [7:0] w, input int t, input string r);
    exp_t e;
    e.is_done = d;
    e.word    = w;
    e.t       = t;
    e.req     = r;
    q.push_back(e);
  endtask

  task automatic check(input logic ok, input string r, input int act, input int exp_v);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0d", r, act, exp_v, cyc);
    end
  endtask

  // Drive a request for one cycle; t0 is the negedge count at which it was presented
  task automatic issue(input logic op, input logic cl, output int t0);
    t0 = cyc;
    open_req  = op;
    close_req = cl;
    @(negedge clk);
    open_req  = 1'b0;
    close_req = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_open(input int t0, input string r);
    push(1'b0, 8'hFE, t0 + H + 1,     r);
    push(1'b0, 8'hF8, t0 + 2*H + 1,   r);
    push(1'b0, 8'hF0, t0 + 3*H + 1,   r);
    push(1'b0, 8'h00, t0 + 4*H + 1,   r);
    push(1'b1, 8'h00, t0 + 5*H + 1,   r);
  endtask

  initial begin
    int t0;
    int t1;
    int tj;
    compared   = 0;
    mismatched = 0;
    cyc        = 0;
    mon_en     = 1'b0;
    open_req   = 1'b0;
    close_req  = 1'b0;
    force_open = 1'b0;
    rst_n      = 1'b0;
    prev_word  = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(sw_ctrl == 8'hFF, "R1 word in reset", sw_ctrl, 8'hFF);
    check(busy == 1'b0,     "R1 busy in reset", busy, 0);
    check(done == 1'b0,     "R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sw_ctrl == 8'hFF && !busy && !done, "R1 after reset release", sw_ctrl, 8'hFF);
    prev_word = sw_ctrl;
    mon_en = 1'b1;

    // R2 R3: open from closed; R6: close in the middle is ignored
    issue(1'b1, 1'b0, t0);
    expect_open(t0, "R2_R3 open ramp");
    check(busy == 1'b1, "R6 busy after accept", busy, 1);
    wait_until(t0 + 2*H + 7);
    issue(1'b0, 1'b1, tj);
    wait_until(t0 + 5*H);
    check(busy == 1'b1, "R6 busy in last hold cycle", busy, 1);
    wait_until(t0 + 5*H + 1);
    check(busy == 1'b0, "R7 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done is one cycle", done, 0);

    // R4: open while already open
    issue(1'b1, 1'b0, t0);
    push(1'b1, 8'h00, t0 + 1, "R4 open on open clamp");
    check(busy == 1'b0, "R4 no busy on skip", busy, 0);
    check(sw_ctrl == 8'h00, "R4 word unchanged", sw_ctrl, 8'h00);
    @(negedge clk);

    // R5: close from open; R7: open presented in the done cycle is taken
    issue(1'b0, 1'b1, t0);
    push(1'b0, 8'hFF, t0 + 1,     "R5 close word");
    push(1'b1, 8'hFF, t0 + H + 1, "R5 close done");
    check(busy == 1'b1, "R5 busy after close", busy, 1);
    wait_until(t0 + H + 1);
    check(done == 1'b1, "R7 done cycle reached", done, 1);
    issue(1'b1, 1'b0, t1);
    expect_open(t1, "R7 open in done cycle");
    check(busy == 1'b1, "R7 request in done cycle accepted", busy, 1);
    // R6: request in the last busy cycle has no effect
    wait_until(t1 + 5*H);
    issue(1'b0, 1'b1, tj);
    check(done == 1'b1 && busy == 1'b0, "R6 last-cycle request dropped", busy, 0);
    repeat (2) @(negedge clk);
    check(sw_ctrl == 8'h00 && !busy, "R6 clamp still open", sw_ctrl, 8'h00);

    // R8: both requests at once, close wins
    issue(1'b1, 1'b1, t0);
    push(1'b0, 8'hFF, t0 + 1,     "R8 close priority word");
    push(1'b1, 8'hFF, t0 + H + 1, "R8 close priority done");
    wait_until(t0 + H + 3);

    // R9: close when already closed still runs a full hold
    issue(1'b0, 1'b1, t0);
    push(1'b1, 8'hFF, t0 + H + 1, "R9 close on closed");
    check(busy == 1'b1, "R9 busy on redundant close", busy, 1);
    wait_until(t0 + H + 3);

    // R4: decision follows the read-back word, not the own output
    force_open = 1'b1;
    issue(1'b1, 1'b0, t0);
    push(1'b1, 8'hFF, t0 + 1, "R4 read-back open");
    check(busy == 1'b0 && sw_ctrl == 8'hFF, "R4 no step on read-back open", sw_ctrl, 8'hFF);
    @(negedge clk);
    force_open = 1'b0;
    repeat (4) @(negedge clk);

    check(q.size() == 0, "all expected events seen", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule